// File: doc/BRIEF.md
# Reloadable Compare Timer with Waveform Output

An upward counter of configurable width that advances on every clock, or once every 2^(ratio+1) clocks when its power-of-two divider is on. When the counter passes all-ones it either reloads from a stored start value or stops at zero. A match register produces compare events. Overflow and compare events drive a waveform output that can emit a one-clock pulse or invert its level. Each event also sets a sticky status flag, and the enabled flags are combined into a single interrupt line.

Software reaches the block through a plain synchronous register port. A write takes effect at the clock edge where `we_i` is high. Reads are combinational from `addr_i`. The addresses are: control 0, counter 1, start value 2, reload strobe 3, match 4, status 5, interrupt enable 6.

Top module: `cmp_timer`

## Requirements
- R1: After reset the control, counter, status and enable registers read 0, `pwm_o` is 0 and `irq_o` is 0.
- R2: While control bit 0 (run) is set, the counter advances by one on every clock if control bit 3 (divider enable) is clear. If bit 3 is set, it advances once every 2^(r+1) clocks, where r is control bits 6:4. The divider restarts from zero while stopped, so the first advance comes 2^(r+1) clocks after a start.
- R3: With control bit 1 (reload enable) set, an advance from all-ones loads the counter from the start value and sets status bit 0.
- R4: With control bit 1 clear, an advance from all-ones clears the counter to 0, clears the run bit and sets status bit 0.
- R5: While stopped the counter holds its value. A restart continues counting from the held value.
- R6: A write to the counter loads the written value. A write of any data to the reload strobe loads the start value. Either write takes priority over counting in that cycle.
- R7: With control bit 2 (compare enable) set, an advance that lands on the match value sets status bit 1. With bit 2 clear it does not.
- R8: Status bits are sticky and are cleared by writing 1 to them; writing 0 leaves them unchanged. `irq_o` is high exactly when a status bit and the same bit of the enable register are both 1.
- R9: With control bits 8:7 (trigger select) = 1 and control bit 9 (toggle) = 1, `pwm_o` inverts on each overflow.
- R10: With control bit 9 = 0, each trigger event drives `pwm_o` to the inverse of the idle level for one clock.
- R11: With trigger select = 2, both overflow and match events trigger the output. Matches are ignored from the write that selects this mode until the first overflow after it.
- R12: When trigger select is written to 0 while running, the output keeps reacting to events up to and including the next overflow, and is then forced to the idle level.
- R13: While stopped, or once triggering has ended, `pwm_o` is held at control bit 10 (idle level) from the clock after that condition holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | CNT_W | Write data |
| rdata_o | output | CNT_W | Read data for `addr_i` |
| pwm_o | output | 1 | Pulse or toggle waveform output |
| irq_o | output | 1 | Combined interrupt, active high |

## Verification
A bad divider or counter state appears at the counter read-back as soon as the next advance is due. It also moves every later overflow and match, so the output edges come a fixed number of clocks away from the values the bench computes. A stale arming flag or stale trigger mode shows at `pwm_o`: in the first period after configuration it appears as an edge that should not be there, and after triggering is cleared it appears as a missing return to the idle level. A wrong status bit reaches `irq_o` in the same clock it is set.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int RATIO_W = 3;

  typedef enum logic [2:0] {
    A_CTRL  = 3'd0,
    A_COUNT = 3'd1,
    A_START = 3'd2,
    A_STRB  = 3'd3,
    A_MATCH = 3'd4,
    A_STAT  = 3'd5,
    A_IEN   = 3'd6
  } addr_e;

  // last field is bit 0
  typedef struct packed {
    logic               idle_lvl;
    logic               toggle;
    logic [1:0]         trig_sel;
    logic [RATIO_W-1:0] ratio;
    logic               div_en;
    logic               cmp_en;
    logic               reload_en;
    logic               run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int RATIO_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               en_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               clr_i,
  output logic               tick_o
);
  localparam int PS_W = 1 << RATIO_W;

  logic [PS_W-1:0] ps_q;
  logic [PS_W-1:0] last;

  assign last   = (PS_W'(2) << ratio_i) - PS_W'(1);
  assign tick_o = run_i && (!en_i || ps_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     ps_q <= '0;
    else if (!run_i || clr_i || !en_i) ps_q <= '0;
    else if (tick_o)                 ps_q <= '0;
    else                             ps_q <= ps_q + PS_W'(1);
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             strobe_i,
  input  logic [CNT_W-1:0] start_i,
  input  logic             reload_en_i,
  input  logic             cmp_en_i,
  input  logic [CNT_W-1:0] match_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o,
  output logic             match_o,
  output logic             stop_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sw_load, at_top;

  assign sw_load = wr_i || strobe_i;
  assign at_top  = (cnt_q == '1);

  always_comb begin
    cnt_d = cnt_q;
    if (wr_i)          cnt_d = wdata_i;
    else if (strobe_i) cnt_d = start_i;
    else if (tick_i)   cnt_d = at_top ? (reload_en_i ? start_i : '0) : cnt_q + CNT_W'(1);
  end

  assign ovf_o   = tick_i && at_top && !sw_load;
  assign match_o = cmp_en_i && tick_i && !sw_load && (cnt_d == match_i);
  assign stop_o  = ovf_o && !reload_en_i;
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tmr_wave.sv
module tmr_wave (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] trig_sel_i,
  input  logic       arm_clr_i,
  input  logic       toggle_i,
  input  logic       idle_i,
  input  logic       ovf_i,
  input  logic       match_i,
  output logic       pwm_o
);
  logic [1:0] eff_q;
  logic       armed_q, out_q, fire, hold_idle;

  // trigger mode in force; a cleared select only takes hold at overflow
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                eff_q <= '0;
    else if (trig_sel_i != '0)  eff_q <= trig_sel_i;
    else if (ovf_i)             eff_q <= '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        armed_q <= 1'b0;
    else if (arm_clr_i) armed_q <= 1'b0;
    else if (ovf_i)     armed_q <= 1'b1;
  end

  assign hold_idle = !run_i || eff_q == '0;
  assign fire      = (ovf_i && eff_q != '0) || (match_i && eff_q[1] && armed_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        out_q <= 1'b0;
    else if (hold_idle) out_q <= idle_i;
    else if (fire)      out_q <= toggle_i ? !out_q : !idle_i;
    else if (!toggle_i) out_q <= idle_i;
  end

  assign pwm_o = out_q;
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [2:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic             pwm_o,
  output logic             irq_o
);
  ctrl_t            ctrl_q, ctrl_new;
  logic [CNT_W-1:0] start_q, match_q, cnt;
  logic [1:0]       stat_q, ien_q, w1c;
  logic             wr_ctrl, wr_cnt, wr_strb, wr_start, wr_match, wr_stat, wr_ien;
  logic             tick, ovf_ev, match_ev, stop_req, arm_clr;
  logic             run, reload_en, idle_lvl;

  assign wr_ctrl  = we_i && addr_i == A_CTRL;
  assign wr_cnt   = we_i && addr_i == A_COUNT;
  assign wr_start = we_i && addr_i == A_START;
  assign wr_strb  = we_i && addr_i == A_STRB;
  assign wr_match = we_i && addr_i == A_MATCH;
  assign wr_stat  = we_i && addr_i == A_STAT;
  assign wr_ien   = we_i && addr_i == A_IEN;

  assign ctrl_new  = ctrl_t'(wdata_i[CTRL_W-1:0]);
  assign run       = ctrl_q.run;
  assign reload_en = ctrl_q.reload_en;
  assign idle_lvl  = ctrl_q.idle_lvl;
  assign arm_clr   = wr_ctrl && ctrl_new.trig_sel[1] && !ctrl_q.trig_sel[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctrl_q <= '0;
    else if (wr_ctrl)  ctrl_q <= ctrl_new;
    else if (stop_req) ctrl_q.run <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      match_q <= '0;
      ien_q   <= '0;
    end else begin
      if (wr_start) start_q <= wdata_i;
      if (wr_match) match_q <= wdata_i;
      if (wr_ien)   ien_q   <= wdata_i[1:0];
    end
  end

  assign w1c = wr_stat ? wdata_i[1:0] : 2'b00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~w1c) | {match_ev, ovf_ev};
  end

  assign irq_o = |(stat_q & ien_q);

  tmr_prescale #(.RATIO_W(RATIO_W)) u_ps (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .en_i    (ctrl_q.div_en),
    .ratio_i (ctrl_q.ratio),
    .clr_i   (wr_cnt || wr_strb),
    .tick_o  (tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .wr_i        (wr_cnt),
    .wdata_i     (wdata_i),
    .strobe_i    (wr_strb),
    .start_i     (start_q),
    .reload_en_i (reload_en),
    .cmp_en_i    (ctrl_q.cmp_en),
    .match_i     (match_q),
    .cnt_o       (cnt),
    .ovf_o       (ovf_ev),
    .match_o     (match_ev),
    .stop_o      (stop_req)
  );

  tmr_wave u_wave (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .trig_sel_i (ctrl_q.trig_sel),
    .arm_clr_i  (arm_clr),
    .toggle_i   (ctrl_q.toggle),
    .idle_i     (idle_lvl),
    .ovf_i      (ovf_ev),
    .match_i    (match_ev),
    .pwm_o      (pwm_o)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:  rdata_o = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
      A_COUNT: rdata_o = cnt;
      A_START: rdata_o = start_q;
      A_MATCH: rdata_o = match_q;
      A_STAT:  rdata_o = {{(CNT_W-2){1'b0}}, stat_q};
      A_IEN:   rdata_o = {{(CNT_W-2){1'b0}}, ien_q};
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             we_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             run_i,
  input logic             div_en_i,
  input logic             reload_en_i,
  input logic [CNT_W-1:0] start_i,
  input logic             idle_i,
  input logic [1:0]       stat_i,
  input logic [1:0]       ien_i,
  input logic             pwm_i,
  input logic             irq_i
);
  // R5
  stopped_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !we_i) |=> (cnt_i == $past(cnt_i)));

  // R2
  plain_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !div_en_i && !we_i && cnt_i != '1) |=> (cnt_i == $past(cnt_i) + CNT_W'(1)));

  // R4
  oneshot_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !div_en_i && !reload_en_i && !we_i && cnt_i == '1) |=> (cnt_i == '0 && !run_i && stat_i[0]));

  // R3
  reload_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !div_en_i && reload_en_i && !we_i && cnt_i == '1) |=> (cnt_i == $past(start_i) && stat_i[0]));

  // R13
  idle_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !we_i) |=> (pwm_i == idle_i));

  // R8
  irq_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_i == 2'b00) |-> !irq_i);
endmodule

bind cmp_timer cmp_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .we_i        (we_i),
  .cnt_i       (cnt),
  .run_i       (run),
  .div_en_i    (ctrl_q.div_en),
  .reload_en_i (reload_en),
  .start_i     (start_q),
  .idle_i      (idle_lvl),
  .stat_i      (stat_q),
  .ien_i       (ien_q),
  .pwm_i       (pwm_o),
  .irq_i       (irq_o)
);

// File: tb/sim_cmp_timer.sv
module sim_cmp_timer;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;
  // control bits
  localparam logic [31:0] RUN = 32'h1, RLD = 32'h2, CMP = 32'h4, DIV = 32'h8;
  localparam logic [31:0] TOG = 32'h200, IDL = 32'h400;
  localparam logic [31:0] TS1 = 32'h080, TS2 = 32'h100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pwm, irq;
  int          total = 0;
  int          bad = 0;
  logic [31:0] v, held;

  always #4 clk = ~clk;

  cmp_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; write lands at the following posedge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_edges(2);
    rst_n = 1'b1;
    wait_edges(1);

    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      check("R1 reg", v, 32'h0);
    end
    check("R1 pwm", {31'b0, pwm}, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R2 plain counting
    wr(3'd1, 32'h0);
    wr(3'd0, RUN);
    wait_edges(37);
    rd(3'd1, v);
    check("R2 nodiv", v, 32'd37);
    wr(3'd0, 32'h0);

    // R2 divider sweep over every ratio
    for (int r = 0; r < 8; r++) begin
      int p, k;
      p = 2 << r;
      k = 2 * p + p / 2 + 1;
      wr(3'd1, 32'h0);
      wr(3'd0, RUN | DIV | (32'(r) << 4));
      wait_edges(k);
      rd(3'd1, v);
      check("R2 div", v, 32'(k / p));
      wr(3'd0, 32'h0);
    end

    // R3 auto reload
    wr(3'd5, 32'h3);
    wr(3'd2, 32'd100);
    wr(3'd1, ONES - 1);
    wr(3'd0, RUN | RLD);
    wait_edges(2);
    rd(3'd1, v);
    check("R3 reload", v, 32'd100);
    wait_edges(1);
    rd(3'd1, v);
    check("R3 after", v, 32'd101);
    rd(3'd5, v);
    check("R3 flag", v & 32'h1, 32'h1);

    // R6 strobe with arbitrary data, then counter write
    wr(3'd3, 32'hDEAD_BEEF);
    rd(3'd1, v);
    check("R6 strobe", v, 32'd100);
    wait_edges(2);
    rd(3'd1, v);
    check("R6 strobe run", v, 32'd102);
    wr(3'd1, 32'd7);
    rd(3'd1, v);
    check("R6 cnt wr", v, 32'd7);

    // R5 freeze and resume
    wr(3'd0, 32'h0);
    rd(3'd1, held);
    wait_edges(10);
    rd(3'd1, v);
    check("R5 frozen", v, held);
    wr(3'd0, RUN);
    wait_edges(3);
    rd(3'd1, v);
    check("R5 resume", v, held + 32'd3);

    // R4 one-shot with R8 interrupt
    wr(3'd0, 32'h0);
    wr(3'd5, 32'h3);
    wr(3'd6, 32'h1);
    wr(3'd1, ONES - 3);
    wr(3'd0, RUN);
    wait_edges(3);
    rd(3'd1, v);
    check("R4 before", v, ONES);
    check("R8 irq low", {31'b0, irq}, 32'h0);
    wait_edges(1);
    rd(3'd1, v);
    check("R4 zero", v, 32'h0);
    rd(3'd0, v);
    check("R4 run cleared", v & RUN, 32'h0);
    rd(3'd5, v);
    check("R4 flag", v, 32'h1);
    check("R8 irq high", {31'b0, irq}, 32'h1);
    wait_edges(5);
    rd(3'd1, v);
    check("R4 stays zero", v, 32'h0);

    // R8 write-one-to-clear
    wr(3'd5, 32'h0);
    rd(3'd5, v);
    check("R8 w0 keeps", v, 32'h1);
    wr(3'd5, 32'h1);
    rd(3'd5, v);
    check("R8 w1 clears", v, 32'h0);
    check("R8 irq gone", {31'b0, irq}, 32'h0);

    // R7 compare enabled / disabled
    wr(3'd6, 32'h2);
    wr(3'd4, 32'd10);
    wr(3'd1, 32'd5);
    wr(3'd0, RUN | CMP);
    wait_edges(4);
    rd(3'd5, v);
    check("R7 early", v, 32'h0);
    wait_edges(1);
    rd(3'd5, v);
    check("R7 hit", v, 32'h2);
    check("R8 match irq", {31'b0, irq}, 32'h1);
    wr(3'd0, 32'h0);
    wr(3'd5, 32'h3);
    wr(3'd1, 32'd5);
    wr(3'd0, RUN);
    wait_edges(6);
    rd(3'd5, v);
    check("R7 disabled", v, 32'h0);
    wr(3'd0, 32'h0);
    wr(3'd6, 32'h0);

    // R9 toggle on overflow, period 4
    wr(3'd2, ONES - 3);
    wr(3'd1, ONES - 3);
    wr(3'd0, RUN | RLD | TS1 | TOG);
    wait_edges(3);
    check("R9 pre", {31'b0, pwm}, 32'h0);
    wait_edges(1);
    check("R9 t1", {31'b0, pwm}, 32'h1);
    wait_edges(3);
    check("R9 hold", {31'b0, pwm}, 32'h1);
    wait_edges(1);
    check("R9 t2", {31'b0, pwm}, 32'h0);

    // R10 positive pulse
    wr(3'd0, 32'h0);
    wr(3'd1, ONES - 3);
    wr(3'd0, RUN | RLD | TS1);
    wait_edges(3);
    check("R10 pos pre", {31'b0, pwm}, 32'h0);
    wait_edges(1);
    check("R10 pos pulse", {31'b0, pwm}, 32'h1);
    wait_edges(1);
    check("R10 pos end", {31'b0, pwm}, 32'h0);

    // R13 idle level while stopped, then R10 negative pulse
    wr(3'd0, IDL);
    wait_edges(1);
    check("R13 forced high", {31'b0, pwm}, 32'h1);
    wr(3'd1, ONES - 3);
    wr(3'd0, RUN | RLD | TS1 | IDL);
    wait_edges(3);
    check("R10 neg pre", {31'b0, pwm}, 32'h1);
    wait_edges(1);
    check("R10 neg pulse", {31'b0, pwm}, 32'h0);
    wait_edges(1);
    check("R10 neg end", {31'b0, pwm}, 32'h1);
    wr(3'd0, 32'h0);
    wait_edges(1);
    check("R13 forced low", {31'b0, pwm}, 32'h0);

    // R11 overflow plus match; start ONES-5, match ONES-2
    wr(3'd2, ONES - 5);
    wr(3'd4, ONES - 2);
    wr(3'd1, ONES - 3);
    wr(3'd0, RUN | RLD | CMP | TS2 | TOG);
    wait_edges(1);
    check("R11 match ignored", {31'b0, pwm}, 32'h0);
    wait_edges(3);
    check("R11 ovf", {31'b0, pwm}, 32'h1);
    wait_edges(3);
    check("R11 match armed", {31'b0, pwm}, 32'h0);
    wait_edges(3);
    check("R11 ovf2", {31'b0, pwm}, 32'h1);

    // R12 clearing trigger select stops at next overflow
    wr(3'd0, RUN | RLD | CMP | TOG);
    wait_edges(2);
    check("R12 match still", {31'b0, pwm}, 32'h0);
    wait_edges(3);
    check("R12 last ovf", {31'b0, pwm}, 32'h1);
    wait_edges(1);
    check("R13 trig off idle", {31'b0, pwm}, 32'h0);
    wait_edges(4);
    check("R12 quiet", {31'b0, pwm}, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule